// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block keeps the interrupt bookkeeping of a USB host controller: a status register that latches events, an enable register that selects which events may latch and raise the interrupt, and a disable register that clears enable bits. All three sit behind a byte-wide register port. Seven event strobes come in from the rest of the controller. An eighth source, the ownership-change request, comes from a command byte. A master enable gates every event source.

The block drives one interrupt level. A routing bit in a control byte chooses where that interrupt goes. When the bit is clear, a level change updates a registered interrupt line. When the bit is set, a rising level becomes a one-cycle pulse on the system-management output. The routing is re-evaluated only when the combined level changes. A routing change alone moves nothing. An ownership request that finds both the master and the ownership enable set also pulses the system-management output directly.

Register byte addresses: status 0x00-0x03, enable 0x04-0x07, disable 0x08-0x0B, control 0x0C-0x0F (routing is bit 0 of byte 0x0D), command 0x10-0x13 (ownership request is bit 3 of byte 0x10). Event bits 0..6 are overrun, done-queue writeback, frame start, resume, unrecoverable error, frame-number overflow and root-hub change. Bit 30 is ownership change and bit 31 is the master enable.

Top module: `hci_irq_ctrl`

## Requirements
- R1: After reset, every register byte reads 0x00, and irq_o and smi_o are 0.
- R2: A write to enable byte 0x04 stores bits 6:0 (bit 7 reads 0). A write to byte 0x07 stores bits 7:6 (master, ownership). Bytes 0x05 and 0x06 ignore writes. Each bit written 1 also clears the matching disable bit.
- R3: A write to the disable bytes 0x08/0x0B clears each enable bit written 1. Reads of 0x08-0x0B return the enable bytes.
- R4: Status byte 0x00 bits 6:0 and byte 0x03 bit 6 are write-1-to-clear. All other status bits read 0 and ignore writes.
- R5: An event strobe sets its status bit only if its own enable bit and the master enable (bit 31) are both set.
- R6: An event that arrives in the same cycle as a clearing write to the same status bit leaves the bit set.
- R7: With routing clear, irq_o takes the OR of (status AND enable) one cycle after that level changes.
- R8: With routing set, a rising level gives a one-cycle smi_o pulse in the next cycle, and irq_o holds its value.
- R9: Writing 1 to bit 3 of byte 0x10 sets status bit 30 (byte 0x03 bit 6). If enable bits 31 and 30 are both set, smi_o pulses for one cycle right after the write.
- R10: A change of the routing bit while the level is steady changes neither irq_o nor smi_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| evt_i | input | 7 | Event strobes, bit n sets status bit n |
| irq_o | output | 1 | Registered interrupt level |
| smi_o | output | 1 | One-cycle system-management pulse |

## Verification
The bench aims at an event and a clear that hit the same bit in the same cycle. A design that gives priority to the clear would lose the event. It also writes the disable register and reads it back. A design without the alias would return the disable bits, or zero, instead of the enable state. It flips the routing bit while the level is steady. A design that re-evaluates continuously would move irq_o or pulse smi_o there. It issues an ownership request with the master enable off, where a wrong design would still pulse smi_o.

// File: rtl/hci_irq_pkg.sv
package hci_irq_pkg;
    localparam int EVT_W  = 7;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_STAT = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_ENA  = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_DIS  = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 5'h10;

    localparam int OWN_REQ_BIT = 3;  // in command byte 0
    localparam int ROUTE_BIT   = 0;  // in control byte 1
    localparam int HI_OWN_BIT  = 6;  // bit 30 within byte 3
    localparam int HI_MST_BIT  = 7;  // bit 31 within byte 3

    typedef struct packed {
        logic             own;
        logic [EVT_W-1:0] ev;
    } stat_t;

    typedef struct packed {
        logic             master;
        logic             own;
        logic [EVT_W-1:0] ev;
    } ena_t;

    function automatic logic [31:0] stat_word(stat_t s);
        logic [31:0] w;
        w = '0;
        w[EVT_W-1:0] = s.ev;
        w[30] = s.own;
        return w;
    endfunction

    function automatic logic [31:0] ena_word(ena_t e);
        logic [31:0] w;
        w = '0;
        w[EVT_W-1:0] = e.ev;
        w[30] = e.own;
        w[31] = e.master;
        return w;
    endfunction
endpackage

// File: rtl/hci_irq_regs.sv
module hci_irq_regs
    import hci_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [EVT_W-1:0]  evt,
    output stat_t             st_q,
    output ena_t              en_q,
    output logic              route_q,
    output logic              own_smi
);
    ena_t  dis_q;
    stat_t st_n;
    ena_t  en_n, dis_n;
    logic  route_n;
    logic  own_req;

    assign own_req = wr && (addr == ADR_CMD) && wdata[OWN_REQ_BIT];
    assign own_smi = own_req && en_q.master && en_q.own;

    always_comb begin
        st_n    = st_q;
        en_n    = en_q;
        dis_n   = dis_q;
        route_n = route_q;
        if (wr) begin
            unique case (addr)
                ADR_STAT:      st_n.ev  = st_q.ev & ~wdata[EVT_W-1:0];
                ADR_STAT + 3:  st_n.own = st_q.own & ~wdata[HI_OWN_BIT];
                ADR_ENA: begin
                    en_n.ev  = wdata[EVT_W-1:0];
                    dis_n.ev = dis_q.ev & ~wdata[EVT_W-1:0];
                end
                ADR_ENA + 3: begin
                    en_n.own     = wdata[HI_OWN_BIT];
                    en_n.master  = wdata[HI_MST_BIT];
                    dis_n.own    = dis_q.own & ~wdata[HI_OWN_BIT];
                    dis_n.master = dis_q.master & ~wdata[HI_MST_BIT];
                end
                ADR_DIS: begin
                    dis_n.ev = wdata[EVT_W-1:0];
                    en_n.ev  = en_q.ev & ~wdata[EVT_W-1:0];
                end
                ADR_DIS + 3: begin
                    dis_n.own    = wdata[HI_OWN_BIT];
                    dis_n.master = wdata[HI_MST_BIT];
                    en_n.own     = en_q.own & ~wdata[HI_OWN_BIT];
                    en_n.master  = en_q.master & ~wdata[HI_MST_BIT];
                end
                ADR_CTRL + 1:  route_n = wdata[ROUTE_BIT];
                ADR_CMD:       if (wdata[OWN_REQ_BIT]) st_n.own = 1'b1;
                default: ;
            endcase
        end
        // events are applied after writes so they win over a same-cycle clear
        if (en_q.master)
            st_n.ev = st_n.ev | (evt & en_q.ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            en_q    <= '0;
            dis_q   <= '0;
            route_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            en_q    <= en_n;
            dis_q   <= dis_n;
            route_q <= route_n;
        end
    end

    logic [8:0] en_bits, dis_bits;
    assign en_bits  = en_q;
    assign dis_bits = dis_q;

    // R3: a bit is never pending in both the enable and the disable register
    a_r3_disjoint: assert property (@(posedge clk) disable iff (rst)
        ((en_bits & dis_bits) == 9'd0));
    // R5: without the master enable an idle status bit stays idle
    a_r5_master_gate: assert property (@(posedge clk) disable iff (rst)
        (!en_q.master && !st_q.ev[0]) |=> !st_q.ev[0]);
    // R6: an enabled event always lands, whatever write comes with it
    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
        (evt[0] && en_q.ev[0] && en_q.master) |=> st_q.ev[0]);
    // R9: ownership request latches status bit 30
    a_r9_own_status: assert property (@(posedge clk) disable iff (rst)
        own_req |=> st_q.own);
endmodule

// File: rtl/hci_irq_route.sv
module hci_irq_route
    import hci_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t st_q,
    input  ena_t  en_q,
    input  logic  route_q,
    input  logic  own_smi,
    output logic  irq_o,
    output logic  smi_o
);
    logic level, lvl_q;
    logic [EVT_W:0] en_src;

    assign en_src = {en_q.own, en_q.ev};
    assign level  = |(st_q & en_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            irq_o <= 1'b0;
            smi_o <= 1'b0;
        end else begin
            lvl_q <= level;
            smi_o <= own_smi || (route_q && level && !lvl_q);
            if ((level != lvl_q) && !route_q)
                irq_o <= level;
        end
    end

    // R7: normal routing follows a level change one cycle later
    a_r7_follow: assert property (@(posedge clk) disable iff (rst)
        ((level != lvl_q) && !route_q) |=> (irq_o == $past(level)));
    // R10: no level change, no change on irq_o
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (level == lvl_q) |=> $stable(irq_o));
    // R8: management routing pulses and leaves irq_o alone
    a_r8_smi_pulse: assert property (@(posedge clk) disable iff (rst)
        (route_q && level && !lvl_q) |=> smi_o);
    a_r8_irq_kept: assert property (@(posedge clk) disable iff (rst)
        (route_q && (level != lvl_q)) |=> $stable(irq_o));
endmodule

// File: rtl/hci_irq_rdmux.sv
module hci_irq_rdmux
    import hci_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  stat_t             st_q,
    input  ena_t              en_q,
    input  logic              route_q,
    output logic [7:0]        rdata
);
    logic [31:0] word;

    always_comb begin
        word = '0;
        unique case (addr[ADDR_W-1:2])
            ADR_STAT[ADDR_W-1:2]: word = stat_word(st_q);
            ADR_ENA[ADDR_W-1:2],
            ADR_DIS[ADDR_W-1:2]:  word = ena_word(en_q);
            ADR_CTRL[ADDR_W-1:2]: word[8 + ROUTE_BIT] = route_q;
            default:              word = '0;
        endcase
        rdata = word[8*addr[1:0] +: 8];
    end
endmodule

// File: rtl/hci_irq_ctrl.sv
module hci_irq_ctrl
    import hci_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              irq_o,
    output logic              smi_o
);
    stat_t st_q;
    ena_t  en_q;
    logic  route_q;
    logic  own_smi;

    hci_irq_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .evt(evt_i), .st_q(st_q), .en_q(en_q), .route_q(route_q), .own_smi(own_smi)
    );

    hci_irq_route u_route (
        .clk(clk), .rst(rst), .st_q(st_q), .en_q(en_q), .route_q(route_q),
        .own_smi(own_smi), .irq_o(irq_o), .smi_o(smi_o)
    );

    hci_irq_rdmux u_rdmux (
        .addr(reg_addr), .st_q(st_q), .en_q(en_q), .route_q(route_q), .rdata(reg_rdata)
    );
endmodule

// File: tb/hci_irq_ctrl_tb.sv
`timescale 1ns/1ps
module hci_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] evt_i = '0;
    logic       irq_o, smi_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench-side expected state: status {own, ev}, enable {master, own, ev}
    logic [7:0] m_st;
    logic [8:0] m_en;
    logic       m_route, m_lvlq, m_irq, m_smi;

    always #2 clk = ~clk;

    hci_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .smi_o(smi_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [4:0] a);
        logic [31:0] w;
        w = '0;
        case (a[4:2])
            3'd0: begin w[6:0] = m_st[6:0]; w[30] = m_st[7]; end
            3'd1, 3'd2: begin w[6:0] = m_en[6:0]; w[30] = m_en[7]; w[31] = m_en[8]; end
            3'd3: w[8] = m_route;
            default: w = '0;
        endcase
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic model_reset();
        m_st = '0; m_en = '0; m_route = 0; m_lvlq = 0; m_irq = 0; m_smi = 0;
    endtask

    task automatic step(input logic w, input logic [4:0] a, input logic [7:0] d,
                        input logic [6:0] e);
        logic [7:0] nst;
        logic [8:0] nen;
        logic nroute, lvl, own;
        reg_wr = w; reg_addr = a; reg_wdata = d; evt_i = e;
        nst = m_st; nen = m_en; nroute = m_route; own = 0;
        if (w) begin
            case (a)
                5'd0:  nst[6:0] = m_st[6:0] & ~d[6:0];
                5'd3:  nst[7] = m_st[7] & ~d[6];
                5'd4:  nen[6:0] = d[6:0];
                5'd7:  nen[8:7] = d[7:6];
                5'd8:  nen[6:0] = m_en[6:0] & ~d[6:0];
                5'd11: nen[8:7] = m_en[8:7] & ~d[7:6];
                5'd13: nroute = d[0];
                5'd16: if (d[3]) begin nst[7] = 1'b1; own = m_en[8] & m_en[7]; end
                default: ;
            endcase
        end
        if (m_en[8]) nst[6:0] = nst[6:0] | (e & m_en[6:0]);
        lvl = |(m_st & m_en[7:0]);
        @(posedge clk);
        #1;
        m_smi = own | (m_route & lvl & ~m_lvlq);
        if ((lvl != m_lvlq) && !m_route) m_irq = lvl;
        m_lvlq = lvl;
        m_st = nst; m_en = nen; m_route = nroute;
        @(negedge clk);
        chk("R7/R8 irq_o", {7'd0, irq_o}, {7'd0, m_irq});
        chk("R8/R9 smi_o", {7'd0, smi_o}, {7'd0, m_smi});
        reg_wr = 0; evt_i = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        reg_wr = 0; evt_i = '0; reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
        chk("model read", v, m_read(a));
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        foreach (u_dut.reg_rdata[i]) ; // no-op to keep loop syntax minimal
        rd_chk("R1 status", 5'd0, 8'h00);
        rd_chk("R1 status hi", 5'd3, 8'h00);
        rd_chk("R1 enable", 5'd4, 8'h00);
        rd_chk("R1 enable hi", 5'd7, 8'h00);
        rd_chk("R1 control", 5'd13, 8'h00);
        chk("R1 irq_o", {7'd0, irq_o}, 8'h00);
        chk("R1 smi_o", {7'd0, smi_o}, 8'h00);

        // R2 enable byte handling
        step(1, 5'd4, 8'hFF, 0);
        rd_chk("R2 enable lo mask", 5'd4, 8'h7F);
        step(1, 5'd5, 8'hFF, 0);
        rd_chk("R2 enable byte1 ignored", 5'd5, 8'h00);
        step(1, 5'd7, 8'hFF, 0);
        rd_chk("R2 enable hi mask", 5'd7, 8'hC0);
        rd_chk("R3 disable alias hi", 5'd11, 8'hC0);

        // R3 disable clears enable and reads it back
        step(1, 5'd8, 8'h01, 0);
        rd_chk("R3 enable after disable", 5'd4, 8'h7E);
        rd_chk("R3 disable alias lo", 5'd8, 8'h7E);

        // R5 event gating by own enable
        step(0, 5'd0, 8'h00, 7'h01);
        rd_chk("R5 disabled event dropped", 5'd0, 8'h00);
        step(0, 5'd0, 8'h00, 7'h02);
        rd_chk("R5 enabled event latched", 5'd0, 8'h02);
        step(0, 5'd0, 8'h00, 0);
        chk("R7 irq_o rises", {7'd0, irq_o}, 8'h01);

        // R4 write-1-to-clear
        step(1, 5'd0, 8'h02, 0);
        rd_chk("R4 w1c clears", 5'd0, 8'h00);
        step(0, 5'd0, 8'h00, 0);
        chk("R7 irq_o falls", {7'd0, irq_o}, 8'h00);
        step(1, 5'd1, 8'hFF, 0);
        rd_chk("R4 byte1 ignored", 5'd1, 8'h00);

        // R6 event versus same-cycle clear
        step(1, 5'd4, 8'h7F, 0);
        step(1, 5'd0, 8'h01, 7'h01);
        rd_chk("R6 event wins", 5'd0, 8'h01);
        step(1, 5'd0, 8'h01, 0);
        step(0, 5'd0, 8'h00, 0);
        step(0, 5'd0, 8'h00, 0);

        // R9 ownership request with both enables
        step(1, 5'd16, 8'h08, 0);
        chk("R9 smi pulse", {7'd0, smi_o}, 8'h01);
        rd_chk("R9 status bit30", 5'd3, 8'h40);
        step(0, 5'd0, 8'h00, 0);
        chk("R9 smi one cycle", {7'd0, smi_o}, 8'h00);
        step(1, 5'd3, 8'h40, 0);
        step(0, 5'd0, 8'h00, 0);
        step(0, 5'd0, 8'h00, 0);

        // R8 routing to management output
        step(1, 5'd13, 8'h01, 0);
        rd_chk("R8 route bit", 5'd13, 8'h01);
        step(0, 5'd0, 8'h00, 7'h04);
        step(0, 5'd0, 8'h00, 0);
        chk("R8 smi pulse", {7'd0, smi_o}, 8'h01);
        chk("R8 irq held", {7'd0, irq_o}, 8'h00);
        step(0, 5'd0, 8'h00, 0);
        chk("R8 smi one cycle", {7'd0, smi_o}, 8'h00);

        // R10 routing flip with steady level
        step(1, 5'd13, 8'h00, 0);
        step(0, 5'd0, 8'h00, 0);
        step(0, 5'd0, 8'h00, 0);
        chk("R10 irq unchanged", {7'd0, irq_o}, 8'h00);
        chk("R10 no smi", {7'd0, smi_o}, 8'h00);
        step(1, 5'd0, 8'h04, 0);
        step(0, 5'd0, 8'h00, 0);

        // R9 ownership request with master off: status only
        step(1, 5'd11, 8'h80, 0);
        step(1, 5'd16, 8'h08, 0);
        chk("R9 no smi without master", {7'd0, smi_o}, 8'h00);
        rd_chk("R9 status set anyway", 5'd3, 8'h40);
        step(0, 5'd0, 8'h00, 7'h7F);
        rd_chk("R5 master off drops events", 5'd0, 8'h00);

        // random mix checked against the bench model
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a;
            logic [7:0] d;
            logic [6:0] e;
            case ($urandom % 8)
                0: a = 5'd0;  1: a = 5'd3;  2: a = 5'd4;  3: a = 5'd7;
                4: a = 5'd8;  5: a = 5'd11; 6: a = 5'd13; default: a = 5'd16;
            endcase
            d = 8'($urandom);
            e = (($urandom % 3) == 0) ? 7'($urandom) : 7'd0;
            step((($urandom % 3) == 0), a, d, e);
            if ((i % 5) == 0) begin
                rd(5'($urandom % 20), v);
                chk("R2/R3/R4 random read", v, m_read(reg_addr));
            end
        end

        // R1 reset mid-run
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        rd_chk("R1 status after reset", 5'd0, 8'h00);
        rd_chk("R1 enable after reset", 5'd7, 8'h00);
        chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

        finish_run();
    end
endmodule